// File: doc/BRIEF.md
# Host-Clocked Serial Byte Engine

This block is the device side of a three-wire serial link in which the host owns the clock, the data line is a shared open-drain wire with a pull-up, and an active-low enable frames each transfer. There are no start or stop patterns and no acknowledge bits. A transfer runs only while enable is low. The engine shifts bytes in from the host, shifts response bytes out to it, and tells the surrounding logic when a whole byte has passed. It also reports a transfer that the host ended in the middle of a byte, and a host that stopped clocking.

All three wire inputs are brought into the system clock domain through two-flop synchronizers. Clock and enable edges are found by comparing successive synchronized samples. A 4-bit counter advances on every serial clock edge, rising and falling, so its wrap after sixteen edges marks a finished byte. A received byte is copied into a holding register at that point. For a response, the surrounding logic loads a byte and selects transmit direction. The engine then pulls the data wire low for each zero bit, most significant bit first, and releases the wire for one bits.

Top module: `ser_byte_engine`

## Requirements
- R1: After reset, rx_byte_o is 0, done_o, abort_o and timeout_o are 0, and ser_data_oe_o is 0, so the data wire is released.
- R2: In receive direction (dir_tx_i = 0), the synchronized data level is shifted into bit 0 of the shift register on each rising serial clock edge. The first bit is therefore the most significant. The completed byte appears on rx_byte_o when the byte finishes.
- R3: Only serial clock edges seen while enable is low are counted. done_o stays 0 after fifteen edges of a byte and becomes 1 after the sixteenth, in both directions.
- R4: done_o stays 1 until done_clr_i is pulsed, or until the first edge of the following byte.
- R5: In transmit direction (dir_tx_i = 1), a tx_load_i pulse loads tx_byte_i. ser_data_oe_o = 1 means the wire is pulled low, and the host reads that as bit value 0. Bit 7 is presented before the first rising edge, and each falling edge moves to the next lower bit.
- R6: In transmit direction, ser_data_oe_o keeps its old value through the second system clock edge after a serial falling edge, and shows the next bit after the third.
- R7: After the last falling edge of a transmitted byte, ser_data_oe_o is 0, because the shift register fills with ones.
- R8: In receive direction, ser_data_oe_o is never 1.
- R9: Enable rising while the edge count is not zero sets abort_o and clears the shift state. abort_o clears on the next enable fall, and the byte that follows is received correctly.
- R10: Serial clock edges while enable is high change nothing. A following byte still takes exactly sixteen edges and arrives intact.
- R11: timeout_o is set when no serial clock edge arrives for TIMEOUT_CYC system cycles while enable is low and a byte is partly transferred. It is not set while enable is low with no byte started. It clears on the next enable fall.
- R12: Enable rising on a byte boundary (edge count zero) does not set abort_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_data_i | input | 1 | Level sensed on the shared data wire |
| ser_data_oe_o | output | 1 | 1 pulls the data wire low |
| ser_en_n_i | input | 1 | Active-low transfer enable |
| dir_tx_i | input | 1 | 1 = transmit to host, 0 = receive from host |
| tx_byte_i | input | 8 | Byte to send |
| tx_load_i | input | 1 | Load strobe for tx_byte_i (transmit direction) |
| rx_byte_o | output | 8 | Last received byte |
| done_o | output | 1 | Byte-complete flag |
| done_clr_i | input | 1 | Clears done_o |
| abort_o | output | 1 | Enable rose in the middle of a byte |
| timeout_o | output | 1 | Serial clock stalled in the middle of a byte |

## Verification
The assertions assume that every level on the serial wires lasts several system cycles, so that no edge is lost in the synchronizers. They also assume that dir_tx_i is held steady for a whole byte, and that tx_load_i is pulsed only between bytes. The stimulus holds each serial level for six system cycles, changes direction only while enable is high, and loads transmit data only while the edge count is zero. The stall windows are placed well clear of the timeout limit on both sides.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
    parameter int unsigned SSX_BITS  = 8;
    localparam int unsigned SSX_CNT_W = $clog2(2 * SSX_BITS);

    typedef struct packed {
        logic [SSX_BITS-1:0]  sr;
        logic [SSX_CNT_W-1:0] cnt;
        logic                 done;
        logic                 abort;
        logic                 tout;
        logic [SSX_BITS-1:0]  rxb;
        logic                 oe;
        logic                 p_clk;
        logic                 p_en;
    } eng_t;
endpackage

// File: rtl/ssx_sync.sv
module ssx_sync #(
    parameter int unsigned     WIDTH   = 1,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ssx_stall_timer.sv
module ssx_stall_timer #(
    parameter int unsigned LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic kick_i,
    output logic expired_o
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (kick_i || !run_i) cnt_d = '0;
        else if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == TOP);

    // R11
    stall_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_i || !run_i) |=> (cnt_q == '0));
endmodule

// File: rtl/ser_byte_engine.sv
module ser_byte_engine
    import ssx_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk_i,
    input  logic                ser_data_i,
    output logic                ser_data_oe_o,
    input  logic                ser_en_n_i,
    input  logic                dir_tx_i,
    input  logic [SSX_BITS-1:0] tx_byte_i,
    input  logic                tx_load_i,
    output logic [SSX_BITS-1:0] rx_byte_o,
    output logic                done_o,
    input  logic                done_clr_i,
    output logic                abort_o,
    output logic                timeout_o
);
    localparam int unsigned MSB = SSX_BITS - 1;
    localparam logic [SSX_CNT_W-1:0] CNT_LAST = '1;

    eng_t st_d, st_q;
    logic [2:0] sync_w;
    logic s_clk, s_dat, s_en;
    logic clk_rise, clk_fall, en_rise, en_fall, live, edge_ok, expired;

    ssx_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_en_n_i, ser_data_i, ser_clk_i}),
        .q_o   (sync_w)
    );

    assign s_clk = sync_w[0];
    assign s_dat = sync_w[1];
    assign s_en  = sync_w[2];

    assign clk_rise = s_clk & ~st_q.p_clk;
    assign clk_fall = ~s_clk & st_q.p_clk;
    assign en_rise  = s_en & ~st_q.p_en;
    assign en_fall  = ~s_en & st_q.p_en;
    assign live     = ~s_en;
    assign edge_ok  = live & (clk_rise | clk_fall);

    ssx_stall_timer #(.LIMIT(TIMEOUT_CYC)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (live && (st_q.cnt != '0)),
        .kick_i    (clk_rise | clk_fall),
        .expired_o (expired)
    );

    always_comb begin
        st_d       = st_q;
        st_d.p_clk = s_clk;
        st_d.p_en  = s_en;

        if (en_rise) begin
            st_d.sr    = '1;
            st_d.cnt   = '0;
            st_d.abort = (st_q.cnt != '0);
        end else if (en_fall) begin
            st_d.abort = 1'b0;
            st_d.tout  = 1'b0;
        end

        if (done_clr_i) st_d.done = 1'b0;

        if (tx_load_i && dir_tx_i) begin
            st_d.sr = tx_byte_i;
        end else if (edge_ok) begin
            if (!dir_tx_i && clk_rise) st_d.sr = {st_q.sr[MSB-1:0], s_dat};
            if (dir_tx_i && clk_fall)  st_d.sr = {st_q.sr[MSB-1:0], 1'b1};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_LAST) begin
                st_d.done = 1'b1;
                if (!dir_tx_i) st_d.rxb = st_d.sr;
            end else if (st_q.cnt == '0) begin
                st_d.done = 1'b0;
            end
        end

        if (expired && live) st_d.tout = 1'b1;

        st_d.oe = dir_tx_i & live & ~st_d.sr[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.sr    <= '1;
            st_q.p_en  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_data_oe_o = st_q.oe;
    assign rx_byte_o     = st_q.rxb;
    assign done_o        = st_q.done;
    assign abort_o       = st_q.abort;
    assign timeout_o     = st_q.tout;

    // R8
    rx_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_tx_i |=> !ser_data_oe_o);

    // R3
    done_rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (st_q.cnt == '0) && ($past(st_q.cnt) == CNT_LAST));

    // R9
    abort_en_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_o) |-> $past(s_en && (st_q.cnt != '0)));

    // R11
    tout_en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> $past(!s_en && (st_q.cnt != '0)));

    // R10
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.p_en && s_en) |=> (st_q.cnt == '0));
endmodule

// File: tb/sim_ser_byte_engine.sv
`timescale 1ns/1ps
module sim_ser_byte_engine;
    localparam int TO   = 64;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, host_d = 1'b1, en_n = 1'b1, dir_tx = 1'b0;
    logic [7:0] txb = 8'h00;
    logic tx_load = 1'b0, done_clr = 1'b0;
    logic oe, done, abort_f, tout;
    logic [7:0] rxb;
    logic wire_d;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign wire_d = host_d & ~oe;

    ser_byte_engine #(.TIMEOUT_CYC(TO)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_data_i(wire_d),
        .ser_data_oe_o(oe), .ser_en_n_i(en_n), .dir_tx_i(dir_tx),
        .tx_byte_i(txb), .tx_load_i(tx_load), .rx_byte_o(rxb),
        .done_o(done), .done_clr_i(done_clr), .abort_o(abort_f),
        .timeout_o(tout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_en(input logic v);
        en_n = v;
        wait_cyc(HALF);
    endtask

    task automatic rx_byte(input logic [7:0] val, input string tag);
        for (int i = 7; i >= 0; i--) begin
            host_d = val[i];
            wait_cyc(HALF);
            chk(oe == 1'b0, "R8", oe, 0);
            sclk = 1'b1;
            wait_cyc(HALF);
            if (i == 0) chk(done == 1'b0, "R3", done, 0);
            sclk = 1'b0;
            wait_cyc(HALF);
        end
        host_d = 1'b1;
        chk(done == 1'b1, "R3", done, 1);
        chk(rxb == val, tag, rxb, val);
    endtask

    task automatic tx_byte(input logic [7:0] val);
        host_d = 1'b1;
        txb = val;
        tx_load = 1'b1;
        wait_cyc(1);
        tx_load = 1'b0;
        wait_cyc(HALF);
        for (int i = 7; i >= 0; i--) begin
            chk(~oe == val[i], "R5", ~oe, val[i]);
            sclk = 1'b1;
            wait_cyc(HALF);
            if (i == 0) chk(done == 1'b0, "R3", done, 0);
            sclk = 1'b0;
            wait_cyc(2);
            chk(oe == ~val[i], "R6", oe, ~val[i]);
            wait_cyc(1);
            if (i > 0) chk(oe == ~val[i-1], "R6", oe, ~val[i-1]);
            else       chk(oe == 1'b0, "R7", oe, 0);
            wait_cyc(HALF - 3);
        end
        chk(done == 1'b1, "R3", done, 1);
    endtask

    task automatic t_reset;
        chk(rxb == 8'h00, "R1", rxb, 0);
        chk({done, abort_f, tout, oe} == 4'b0, "R1", {done, abort_f, tout, oe}, 0);
    endtask

    task automatic t_rx;
        set_en(1'b0);
        rx_byte(8'h3C, "R2");
        rx_byte(8'hC5, "R2");
        set_en(1'b1);
    endtask

    task automatic t_done_abort;
        set_en(1'b0);
        rx_byte(8'h81, "R2");
        wait_cyc(20);
        chk(done == 1'b1, "R4", done, 1);
        done_clr = 1'b1;
        wait_cyc(1);
        done_clr = 1'b0;
        chk(done == 1'b0, "R4", done, 0);
        rx_byte(8'h7E, "R2");
        host_d = 1'b0;
        wait_cyc(HALF);
        sclk = 1'b1;
        wait_cyc(HALF);
        chk(done == 1'b0, "R4", done, 0);
        sclk = 1'b0;
        wait_cyc(HALF);
        set_en(1'b1);
        chk(abort_f == 1'b1, "R9", abort_f, 1);
        set_en(1'b0);
        chk(abort_f == 1'b0, "R9", abort_f, 0);
        rx_byte(8'h96, "R9");
        set_en(1'b1);
        chk(abort_f == 1'b0, "R12", abort_f, 0);
    endtask

    task automatic t_idle_edges;
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b1;
            wait_cyc(HALF);
            sclk = 1'b0;
            wait_cyc(HALF);
        end
        set_en(1'b0);
        rx_byte(8'h5A, "R10");
        set_en(1'b1);
    endtask

    task automatic t_tx;
        dir_tx = 1'b1;
        set_en(1'b0);
        tx_byte(8'hA5);
        tx_byte(8'h3C);
        set_en(1'b1);
        dir_tx = 1'b0;
        wait_cyc(2);
    endtask

    task automatic t_timeout;
        set_en(1'b0);
        wait_cyc(TO + 10);
        chk(tout == 1'b0, "R11", tout, 0);
        sclk = 1'b1; wait_cyc(HALF);
        sclk = 1'b0; wait_cyc(HALF);
        sclk = 1'b1;
        wait_cyc(TO / 2);
        chk(tout == 1'b0, "R11", tout, 0);
        wait_cyc(TO);
        chk(tout == 1'b1, "R11", tout, 1);
        set_en(1'b1);
        sclk = 1'b0;
        wait_cyc(HALF);
        set_en(1'b0);
        chk(tout == 1'b0, "R11", tout, 0);
        set_en(1'b1);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(4);
        t_reset();
        t_rx();
        t_done_abort();
        t_idle_edges();
        t_tx();
        t_timeout();
        finish_run();
    end
endmodule